// File: doc/BRIEF.md
# Serial Addressed Parameter Register File

This block sits on the sensor side of a three-wire configuration link and fills a bank of eight 8-bit parameter registers from a serial stream. A host shifts in 11-bit words. Each word holds a register address, followed by the data byte. The host raises a load strobe in the same cycle it presents the last bit. The block samples the bit stream on the rising clock edge. A complete word is captured on the rising edge where the load strobe is seen, and it is written into the addressed register on the falling edge that follows.

The register contents are not offered as raw bytes. They are broken out onto named parameter ports: edge mode, edge direction, gain, the 16-bit exposure time, the three 1-D kernel weights, the edge ratio, the invert flag, the bias select, the zero-calibration code and the output offset. A bit counter measures each word. If the load strobe arrives after any number of bits other than eleven, the word is dropped and a one-cycle error pulse is raised. A separate active-low register-clear input empties the bank without disturbing the serial receiver.

Top module: `ser_param_regfile`

## Requirements
- R1: While `rst_ni` is low, and after it is released, every parameter output and `err_o` read 0.
- R2: A word is 11 bits sent most significant bit first on `sdata_i`, one bit per rising edge: 3 address bits (bit 2 first), then 8 data bits (bit 7 first). `load_i` is high in the cycle of the final data bit.
- R3: A captured word leaves the outputs unchanged until the next falling clock edge, and the new value is visible after that falling edge.
- R4: A valid word changes only the register selected by its address. All other registers keep their values.
- R5: Address 1 drives `edge_excl_o` from bit 7, `edge_dir_o` from bits 6:5 and `gain_o` from bits 4:0.
- R6: `expo_o` is {register 2, register 3}: address 2 holds the high byte and address 3 holds the low byte.
- R7: Addresses 4, 5 and 6 drive `kern_p_o`, `kern_m_o` and `kern_x_o` unchanged.
- R8: Address 7 drives `ratio_o` from bits 7:4, `invert_o` from bit 3 and `vref_o` from bits 2:0. Address 0 drives `zero_cal_o` from bits 7:6 and `out_ofs_o` from bits 5:0.
- R9: A load strobe that follows any bit count other than 11 since the previous strobe or reset writes nothing. It raises `err_o` for exactly the one cycle after that rising edge.
- R10: With `reg_clr_ni` low at a falling edge, all eight registers become 0x00. This takes priority over a word committing at that same edge.
- R11: The bit counter restarts at the load strobe, so a new word may begin in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Serial and commit clock |
| rst_ni | input | 1 | Asynchronous active-low reset of the whole block |
| reg_clr_ni | input | 1 | Active-low register-bank clear, sampled on the falling edge |
| sdata_i | input | 1 | Serial data bit |
| load_i | input | 1 | Word-end strobe, high with the last bit |
| edge_excl_o | output | 1 | Exclusive edge mode flag |
| edge_dir_o | output | 2 | Edge direction select |
| gain_o | output | 5 | Output gain code |
| expo_o | output | 16 | Exposure time |
| kern_p_o | output | 8 | Kernel centre weight |
| kern_m_o | output | 8 | Kernel neighbour weight |
| kern_x_o | output | 8 | Kernel third weight |
| ratio_o | output | 4 | Edge enhancement ratio |
| invert_o | output | 1 | Output invert flag |
| vref_o | output | 3 | Output bias select |
| zero_cal_o | output | 2 | Zero-point calibration code |
| out_ofs_o | output | 6 | Output reference offset |
| err_o | output | 1 | One-cycle pulse on a dropped word |

## Verification
The bench builds the block with its default 3-bit address and 8-bit data widths. This gives an 11-bit word and a bit counter that saturates just above eleven, so both short and over-long words can be produced with a few extra cycles. The bench sends every word back to back with no idle gaps, which keeps each bit count exact and exercises the counter restart after every strobe. At the first bit of each following word, the bench checks the bank twice: once before the falling edge, against the state before the previous word, and once after it, against the updated state. A clear pulse placed on the commit edge demonstrates the clear priority.

// File: rtl/ser_param_pkg.sv
package ser_param_pkg;
  localparam int ADDR_W  = 3;
  localparam int DATA_W  = 8;
  localparam int NREG    = 1 << ADDR_W;
  localparam int WORD_W  = ADDR_W + DATA_W;
  localparam int CNT_W   = $clog2(WORD_W + 1);
  localparam int EXPO_W  = 2 * DATA_W;

  // register addresses whose contents are decoded into fields
  localparam int A_OFS  = 0;
  localparam int A_MODE = 1;
  localparam int A_EXPH = 2;
  localparam int A_EXPL = 3;
  localparam int A_KP   = 4;
  localparam int A_KM   = 5;
  localparam int A_KX   = 6;
  localparam int A_TUNE = 7;

  typedef logic [DATA_W-1:0] byte_t;

  typedef struct packed {
    logic              edge_excl;
    logic [1:0]        edge_dir;
    logic [4:0]        gain;
    logic [EXPO_W-1:0] expo;
    byte_t             kern_p;
    byte_t             kern_m;
    byte_t             kern_x;
    logic [3:0]        ratio;
    logic              invert;
    logic [2:0]        vref;
    logic [1:0]        zero_cal;
    logic [5:0]        out_ofs;
  } fields_t;
endpackage

// File: rtl/ser_param_shift.sv
module ser_param_shift
  import ser_param_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sdata_i,
  input  logic          load_i,
  output logic          cap_vld_o,
  output logic [AW-1:0] cap_addr_o,
  output logic [DW-1:0] cap_data_o,
  output logic          err_o
);
  localparam int WW   = AW + DW;
  localparam int CW   = $clog2(WW + 1);
  localparam logic [CW-1:0] CNT_FULL = CW'(WW - 1);
  localparam logic [CW-1:0] CNT_SAT  = CW'(WW);

  logic [WW-2:0] sh_q;
  logic [CW-1:0] cnt_q;
  logic [WW-1:0] word;
  logic          full;

  // final bit comes straight from the pin in the strobe cycle
  assign word = {sh_q, sdata_i};
  assign full = (cnt_q == CNT_FULL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q       <= '0;
      cnt_q      <= '0;
      cap_vld_o  <= 1'b0;
      cap_addr_o <= '0;
      cap_data_o <= '0;
      err_o      <= 1'b0;
    end else begin
      cap_vld_o <= load_i & full;
      err_o     <= load_i & ~full;
      if (load_i) begin
        cnt_q      <= '0;
        cap_addr_o <= word[WW-1 -: AW];
        cap_data_o <= word[DW-1:0];
      end else begin
        sh_q <= {sh_q[WW-3:0], sdata_i};
        if (cnt_q != CNT_SAT) cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ser_param_bank.sv
module ser_param_bank
  import ser_param_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W,
  parameter int NR = 1 << AW
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  clr_ni,
  input  logic                  cap_vld_i,
  input  logic [AW-1:0]         cap_addr_i,
  input  logic [DW-1:0]         cap_data_i,
  output logic [NR-1:0][DW-1:0] regs_o
);
  for (genvar g = 0; g < NR; g++) begin : g_reg
    // commit on the falling edge after the capturing rising edge
    always_ff @(negedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        regs_o[g] <= '0;
      end else if (!clr_ni) begin
        regs_o[g] <= '0;
      end else if (cap_vld_i && (cap_addr_i == AW'(g))) begin
        regs_o[g] <= cap_data_i;
      end
    end
  end
endmodule

// File: rtl/ser_param_fields.sv
module ser_param_fields
  import ser_param_pkg::*;
(
  input  logic [NREG-1:0][DATA_W-1:0] regs_i,
  output fields_t                     fld_o
);
  always_comb begin
    fld_o           = '0;
    fld_o.edge_excl = regs_i[A_MODE][7];
    fld_o.edge_dir  = regs_i[A_MODE][6:5];
    fld_o.gain      = regs_i[A_MODE][4:0];
    fld_o.expo      = {regs_i[A_EXPH], regs_i[A_EXPL]};
    fld_o.kern_p    = regs_i[A_KP];
    fld_o.kern_m    = regs_i[A_KM];
    fld_o.kern_x    = regs_i[A_KX];
    fld_o.ratio     = regs_i[A_TUNE][7:4];
    fld_o.invert    = regs_i[A_TUNE][3];
    fld_o.vref      = regs_i[A_TUNE][2:0];
    fld_o.zero_cal  = regs_i[A_OFS][7:6];
    fld_o.out_ofs   = regs_i[A_OFS][5:0];
  end
endmodule

// File: rtl/ser_param_regfile.sv
module ser_param_regfile
  import ser_param_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_clr_ni,
  input  logic              sdata_i,
  input  logic              load_i,
  output logic              edge_excl_o,
  output logic [1:0]        edge_dir_o,
  output logic [4:0]        gain_o,
  output logic [EXPO_W-1:0] expo_o,
  output logic [DATA_W-1:0] kern_p_o,
  output logic [DATA_W-1:0] kern_m_o,
  output logic [DATA_W-1:0] kern_x_o,
  output logic [3:0]        ratio_o,
  output logic              invert_o,
  output logic [2:0]        vref_o,
  output logic [1:0]        zero_cal_o,
  output logic [5:0]        out_ofs_o,
  output logic              err_o
);
  logic                        cap_vld;
  logic [ADDR_W-1:0]           cap_addr;
  logic [DATA_W-1:0]           cap_data;
  logic [NREG-1:0][DATA_W-1:0] regs;
  fields_t                     fld;

  ser_param_shift #(.AW(ADDR_W), .DW(DATA_W)) i_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sdata_i    (sdata_i),
    .load_i     (load_i),
    .cap_vld_o  (cap_vld),
    .cap_addr_o (cap_addr),
    .cap_data_o (cap_data),
    .err_o      (err_o)
  );

  ser_param_bank #(.AW(ADDR_W), .DW(DATA_W), .NR(NREG)) i_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_ni     (reg_clr_ni),
    .cap_vld_i  (cap_vld),
    .cap_addr_i (cap_addr),
    .cap_data_i (cap_data),
    .regs_o     (regs)
  );

  ser_param_fields i_fields (
    .regs_i (regs),
    .fld_o  (fld)
  );

  assign edge_excl_o = fld.edge_excl;
  assign edge_dir_o  = fld.edge_dir;
  assign gain_o      = fld.gain;
  assign expo_o      = fld.expo;
  assign kern_p_o    = fld.kern_p;
  assign kern_m_o    = fld.kern_m;
  assign kern_x_o    = fld.kern_x;
  assign ratio_o     = fld.ratio;
  assign invert_o    = fld.invert;
  assign vref_o      = fld.vref;
  assign zero_cal_o  = fld.zero_cal;
  assign out_ofs_o   = fld.out_ofs;
endmodule

// File: rtl/ser_param_regfile_chk.sv
module ser_param_regfile_chk #(
  parameter int W = 64
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         reg_clr_ni,
  input logic         load_i,
  input logic         err_o,
  input logic [W-1:0] regs_i
);
  // an error pulse always follows a sampled strobe
  assert_err_after_load_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(load_i));

  // a dropped word writes nothing
  assert_err_no_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && reg_clr_ni) |-> $stable(regs_i));

  // without a strobe on the previous edge the bank holds
  assert_hold_without_load_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(load_i) && reg_clr_ni && $past(reg_clr_ni)) |-> $stable(regs_i));

  // clear empties the whole bank
  assert_clear_empties_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!reg_clr_ni && !$past(reg_clr_ni)) |-> (regs_i == '0));
endmodule

bind ser_param_regfile ser_param_regfile_chk #(.W(64)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .reg_clr_ni (reg_clr_ni),
  .load_i     (load_i),
  .err_o      (err_o),
  .regs_i     ({ratio_o, invert_o, vref_o, kern_x_o, kern_m_o, kern_p_o,
                expo_o, edge_excl_o, edge_dir_o, gain_o, zero_cal_o, out_ofs_o})
);

// File: tb/test_ser_param_regfile.sv
module test_ser_param_regfile;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic reg_clr_ni = 1'b1;
  logic sdata_i = 1'b0;
  logic load_i = 1'b0;
  logic       edge_excl_o, invert_o, err_o;
  logic [1:0] edge_dir_o, zero_cal_o;
  logic [4:0] gain_o;
  logic [15:0] expo_o;
  logic [7:0] kern_p_o, kern_m_o, kern_x_o;
  logic [3:0] ratio_o;
  logic [2:0] vref_o;
  logic [5:0] out_ofs_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  bit skip_wait = 0;
  logic [63:0] mdl = '0;
  logic [63:0] mdl_old = '0;
  logic exp_err = 1'b0;

  always #5 clk = ~clk;

  ser_param_regfile i_ser_param_regfile (
    .clk_i(clk), .rst_ni(rst_ni), .reg_clr_ni(reg_clr_ni), .sdata_i(sdata_i), .load_i(load_i),
    .edge_excl_o(edge_excl_o), .edge_dir_o(edge_dir_o), .gain_o(gain_o), .expo_o(expo_o),
    .kern_p_o(kern_p_o), .kern_m_o(kern_m_o), .kern_x_o(kern_x_o), .ratio_o(ratio_o),
    .invert_o(invert_o), .vref_o(vref_o), .zero_cal_o(zero_cal_o), .out_ofs_o(out_ofs_o),
    .err_o(err_o)
  );

  // {address, data} words, all sent back to back (R11)
  localparam logic [10:0] VEC [12] = '{
    {3'd1, 8'hA5}, {3'd2, 8'h3C}, {3'd3, 8'hC1}, {3'd4, 8'h81},
    {3'd5, 8'h7E}, {3'd6, 8'h12}, {3'd7, 8'h9B}, {3'd0, 8'hE6},
    {3'd1, 8'h5A}, {3'd3, 8'h01}, {3'd7, 8'h64}, {3'd0, 8'h19}
  };

  // bank rebuilt from the ports: reg r at bits r*8 +: 8
  function automatic logic [63:0] bank();
    logic [63:0] b;
    b[0*8 +: 8] = {zero_cal_o, out_ofs_o};
    b[1*8 +: 8] = {edge_excl_o, edge_dir_o, gain_o};
    b[2*8 +: 8] = expo_o[15:8];
    b[3*8 +: 8] = expo_o[7:0];
    b[4*8 +: 8] = kern_p_o;
    b[5*8 +: 8] = kern_m_o;
    b[6*8 +: 8] = kern_x_o;
    b[7*8 +: 8] = {ratio_o, invert_o, vref_o};
    return b;
  endfunction

  function automatic string req_of(int r);
    case (r)
      1: return "R5";
      2, 3: return "R6";
      4, 5, 6: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic chk_bank(string ctx, logic [63:0] exp);
    logic [63:0] got = bank();
    for (int r = 0; r < 8; r++)
      chk($sformatf("%s %s R2 R4 reg%0d", ctx, req_of(r), r),
          32'(got[r*8 +: 8]), 32'(exp[r*8 +: 8]));
  endtask

  // send n bits MSB first, strobe on the last; checks previous word at first bit
  task automatic send(logic [15:0] bits, int n, bit clr_first);
    for (int i = n - 1; i >= 0; i--) begin
      if (skip_wait) skip_wait = 0;
      else @(posedge clk);
      #2;
      sdata_i = bits[i];
      load_i  = (i == 0);
      if (i == n - 2) reg_clr_ni = 1'b1;
      if (i == n - 1) begin
        chk_bank("R3 before fall", mdl_old);
        if (clr_first) begin
          reg_clr_ni = 1'b0;
          mdl = '0;
        end
        #4;
        chk_bank(clr_first ? "R10 clear" : "R3 after fall", mdl);
        chk("R9 err_o", 32'(err_o), 32'(exp_err));
      end
    end
    mdl_old = mdl;
    if (n == 11) mdl[bits[10:8]*8 +: 8] = bits[7:0];
    exp_err = (n != 11);
  endtask

  task automatic flush();
    @(posedge clk);
    #2;
    sdata_i = 1'b0;
    load_i = 1'b0;
    reg_clr_ni = 1'b1;
    chk_bank("R3 before fall", mdl_old);
    #4;
    chk_bank("R3 after fall", mdl);
    chk("R9 err_o", 32'(err_o), 32'(exp_err));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2;
    chk_bank("R1 in reset", 64'h0);
    chk("R1 err_o", 32'(err_o), 32'h0);
    @(posedge clk);
    #1;
    rst_ni = 1'b1;
    skip_wait = 1;
    #1;
    chk_bank("R1 after release", 64'h0);
    #1;
    // table walk, contiguous stream (R11)
    foreach (VEC[k]) send({5'd0, VEC[k]}, 11, 1'b0);
    // short word: 10 bits, dropped (R9)
    send(16'h02AA, 10, 1'b0);
    send({5'd0, 3'd4, 8'h33}, 11, 1'b0);
    // long word: 12 bits, dropped (R9)
    send(16'h0FFF, 12, 1'b0);
    // strobe alone: zero bits (R9)
    send(16'h0001, 1, 1'b0);
    send({5'd0, 3'd6, 8'hC3}, 11, 1'b0);
    // clear on the commit edge of the 0x6C3 word: whole bank empties (R10)
    send({5'd0, 3'd2, 8'hF0}, 11, 1'b1);
    send({5'd0, 3'd7, 8'h0F}, 11, 1'b0);
    flush();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule